// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block holds two banks of address translation windows: one bank for outbound traffic and one bank for inbound traffic. Each bank has `NUM_WIN` windows. Software reaches the windows through one small register port. A selector register chooses the bank and the window, and a fixed group of offsets then reads or writes the fields of the window it selects. Every window has a 64-bit base, a 32-bit limit, a 64-bit target, a type word and a control word that carries the enable bit.

A lookup port gives an address and a direction. One clock later the block returns the winning window. For a memory-type window the result is the translated address. For a configuration-type window the result is a bus number, a device/function number and a register offset, ready for a configuration request. If no enabled window matches, the result is a miss.

Base, limit, type and enable are staged. They reach the lookup logic only when the control word is written. The target is used as soon as it is written.

Top module: `xlat_window_unit`

## Requirements
- R1: After reset, the selector reads 0 and every window reads base 0, target 0, limit 0xFFFFFFFF and type 0 (memory). The control word reads 0 in every window except inbound window 0, which reads 0x80000000 and is enabled.
- R2: The selector sits at offset 0x900. Bits [3:0] are the window index, and bit 31 picks the inbound bank (1) or the outbound bank (0). A read of the selector returns the whole 32-bit value last written.
- R3: When the selected index is not below `NUM_WIN`, window field reads return 0 and window field writes change no window.
- R4: The field offsets act on the selected window: type 0x904, control 0x908, base low 0x90C, base high 0x910, limit 0x914, target low 0x918, target high 0x91C. Base, limit and type writes do not change lookups until the control word at 0x908 is written.
- R5: Bit 31 of the control word enables the window. A disabled window never matches.
- R6: A window matches an address A when base <= A <= {base[63:32], limit}. Both ends of the range are included.
- R7: For a memory-type window (type word 0), a lookup returns target + (A − base). The result is valid exactly one cycle after the lookup.
- R8: A non-zero type word makes the window a configuration window. A hit on it sets the configuration flag and returns bus = target[31:24], device/function = target[23:16] and offset = (A − base)[11:0].
- R9: A write to target high replaces target bits [63:32] and keeps the low half. Target writes take effect on lookups at once, without a control word write.
- R10: When several enabled windows match, the lowest index wins. An address that no window matches gives a miss, and hit and miss are never both set.
- R11: At reset, inbound lookups of any address below 2^32 hit inbound window 0 and pass through unchanged. Outbound lookups miss.
- R12: The lookup direction input picks the bank: 0 is outbound and 1 is inbound. The windows of the other bank have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_dir | input | 1 | Lookup bank: 0 outbound, 1 inbound |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | An enabled window matched |
| res_miss | output | 1 | No window matched |
| res_cfg | output | 1 | The winning window is configuration type |
| res_win | output | 4 | Index of the winning window |
| res_addr | output | 64 | Translated address |
| res_bus | output | 8 | Configuration bus number |
| res_devfn | output | 8 | Configuration device/function number |
| res_cfg_off | output | 12 | Configuration register offset |

## Verification
The bench targets five corner cases, each with a wrong design it would expose:
- **Staging.** An address is looked up between writes of the range fields and the control word write. A design that commits early would translate through the half-written range.
- **Range edges.** The first and last addresses of a window, and one address past each end, are looked up. An off-by-one compare would drop the limit address or accept the address after it.
- **Bad index.** Writes are made with an out-of-range index. A design that drops the upper index bits would corrupt a real window, and the read-back shows it.
- **Target high write.** The high half of the target is rewritten. A design that clears the low half would return a wrong target and a wrong translation.
- **Overlap and direction.** Overlapping windows and both banks are exercised, so that a reversed priority or a wrong bank select shows up in the reported window.

Random window layouts and random addresses then run against a reference model in the bench.

// File: rtl/xwu_pkg.sv
package xwu_pkg;

    localparam logic [11:0] OFF_VP       = 12'h900;
    localparam logic [11:0] OFF_TYPE     = 12'h904;
    localparam logic [11:0] OFF_CTRL     = 12'h908;
    localparam logic [11:0] OFF_BASE_LO  = 12'h90C;
    localparam logic [11:0] OFF_BASE_HI  = 12'h910;
    localparam logic [11:0] OFF_LIMIT    = 12'h914;
    localparam logic [11:0] OFF_TGT_LO   = 12'h918;
    localparam logic [11:0] OFF_TGT_HI   = 12'h91C;

    localparam int CFG_OFF_W = 12;
    localparam logic [31:0] CTRL_EN_BIT = 32'h8000_0000;

    typedef enum logic [3:0] {
        FLD_NONE, FLD_VP, FLD_TYPE, FLD_CTRL,
        FLD_BASE_LO, FLD_BASE_HI, FLD_LIMIT, FLD_TGT_LO, FLD_TGT_HI
    } fld_e;

    // Fields as software sees them.
    typedef struct packed {
        logic [63:0] base;
        logic [31:0] limit;
        logic [63:0] target;
        logic [31:0] kind;
        logic [31:0] ctrl;
    } win_shadow_t;

    // Values the lookup logic uses, updated on a control word write.
    typedef struct packed {
        logic [63:0] base;
        logic [31:0] limit;
        logic        is_cfg;
        logic        en;
    } win_active_t;

    function automatic fld_e decode_fld(input logic [11:0] a);
        case (a)
            OFF_VP:      return FLD_VP;
            OFF_TYPE:    return FLD_TYPE;
            OFF_CTRL:    return FLD_CTRL;
            OFF_BASE_LO: return FLD_BASE_LO;
            OFF_BASE_HI: return FLD_BASE_HI;
            OFF_LIMIT:   return FLD_LIMIT;
            OFF_TGT_LO:  return FLD_TGT_LO;
            OFF_TGT_HI:  return FLD_TGT_HI;
            default:     return FLD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/xwu_window.sv
module xwu_window
    import xwu_pkg::*;
#(
    parameter bit RST_EN = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  fld_e                 wr_fld,
    input  logic [31:0]          wr_data,
    input  logic [63:0]          lk_addr,
    output win_shadow_t          shadow_o,
    output logic                 hit_o,
    output logic                 is_cfg_o,
    output logic [63:0]          xlat_o,
    output logic [CFG_OFF_W-1:0] off_o
);

    typedef struct packed {
        win_shadow_t sh;
        win_active_t act;
    } st_t;

    st_t st_d, st_q;
    logic [63:0] upper;
    logic [63:0] delta;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_fld)
                FLD_TYPE:    st_d.sh.kind = wr_data;
                FLD_BASE_LO: st_d.sh.base[31:0] = wr_data;
                FLD_BASE_HI: st_d.sh.base[63:32] = wr_data;
                FLD_LIMIT:   st_d.sh.limit = wr_data;
                FLD_TGT_LO:  st_d.sh.target[31:0] = wr_data;
                FLD_TGT_HI:  st_d.sh.target[63:32] = wr_data;
                FLD_CTRL: begin
                    st_d.sh.ctrl      = wr_data;
                    st_d.act.base     = st_q.sh.base;
                    st_d.act.limit    = st_q.sh.limit;
                    st_d.act.is_cfg   = (st_q.sh.kind != 32'd0);
                    st_d.act.en       = wr_data[31];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh.base    <= '0;
            st_q.sh.limit   <= 32'hFFFF_FFFF;
            st_q.sh.target  <= '0;
            st_q.sh.kind    <= '0;
            st_q.sh.ctrl    <= RST_EN ? CTRL_EN_BIT : 32'd0;
            st_q.act.base   <= '0;
            st_q.act.limit  <= 32'hFFFF_FFFF;
            st_q.act.is_cfg <= 1'b0;
            st_q.act.en     <= RST_EN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        upper    = {st_q.act.base[63:32], st_q.act.limit};
        delta    = lk_addr - st_q.act.base;
        hit_o    = st_q.act.en && (lk_addr >= st_q.act.base) && (lk_addr <= upper);
        is_cfg_o = st_q.act.is_cfg;
        xlat_o   = st_q.sh.target + delta;
        off_o    = delta[CFG_OFF_W-1:0];
        shadow_o = st_q.sh;
    end

endmodule

// File: rtl/xwu_pick.sv
module xwu_pick #(
    parameter int N    = 4,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
    import xwu_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic        lk_dir,
    input  logic [63:0] lk_addr,
    output logic        res_valid,
    output logic        res_hit,
    output logic        res_miss,
    output logic        res_cfg,
    output logic [3:0]  res_win,
    output logic [63:0] res_addr,
    output logic [7:0]  res_bus,
    output logic [7:0]  res_devfn,
    output logic [11:0] res_cfg_off
);

    localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        logic        valid;
        logic        hit;
        logic        miss;
        logic        cfg;
        logic [3:0]  win;
        logic [63:0] addr;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [11:0] off;
    } res_t;

    typedef struct packed {
        logic [31:0] vp;
        res_t        res;
    } top_st_t;

    top_st_t st_d, st_q;

    fld_e              fld;
    logic              vp_ok;
    logic [IW-1:0]     vp_idx;
    logic              vp_in;

    win_shadow_t       shadow [2][NUM_WIN];
    logic [NUM_WIN-1:0] hit_v  [2];
    logic [NUM_WIN-1:0] cfg_v  [2];
    logic [63:0]       xl     [2][NUM_WIN];
    logic [CFG_OFF_W-1:0] offs [2][NUM_WIN];

    logic [NUM_WIN-1:0] hv_sel;
    logic              pk_found;
    logic [IW-1:0]     pk_idx;
    win_shadow_t       rd_sh;

    assign fld    = decode_fld(reg_addr);
    assign vp_ok  = 32'(st_q.vp[3:0]) < NUM_WIN;
    assign vp_idx = st_q.vp[IW-1:0];
    assign vp_in  = st_q.vp[31];

    for (genvar d = 0; d < 2; d++) begin : g_dir
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            logic sel;
            assign sel = vp_ok && (vp_in == d[0]) && (vp_idx == IW'(i));
            xwu_window #(
                .RST_EN((d == 1) && (i == 0))
            ) win_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (reg_we && sel),
                .wr_fld   (fld),
                .wr_data  (reg_wdata),
                .lk_addr  (lk_addr),
                .shadow_o (shadow[d][i]),
                .hit_o    (hit_v[d][i]),
                .is_cfg_o (cfg_v[d][i]),
                .xlat_o   (xl[d][i]),
                .off_o    (offs[d][i])
            );
        end
    end

    assign hv_sel = lk_dir ? hit_v[1] : hit_v[0];

    xwu_pick #(.N(NUM_WIN)) pick_i (
        .req   (hv_sel),
        .found (pk_found),
        .idx   (pk_idx)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we && fld == FLD_VP) begin
            st_d.vp = reg_wdata;
        end
        st_d.res.valid = lk_valid;
        st_d.res.hit   = lk_valid && pk_found;
        st_d.res.miss  = lk_valid && !pk_found;
        st_d.res.cfg   = lk_valid && pk_found && cfg_v[lk_dir][pk_idx];
        st_d.res.win   = 4'(pk_idx);
        st_d.res.addr  = xl[lk_dir][pk_idx];
        st_d.res.bus   = shadow[lk_dir][pk_idx].target[31:24];
        st_d.res.devfn = shadow[lk_dir][pk_idx].target[23:16];
        st_d.res.off   = offs[lk_dir][pk_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_sh     = shadow[vp_in][vp_idx];
        reg_rdata = 32'd0;
        if (fld == FLD_VP) begin
            reg_rdata = st_q.vp;
        end else if (vp_ok) begin
            case (fld)
                FLD_TYPE:    reg_rdata = rd_sh.kind;
                FLD_CTRL:    reg_rdata = rd_sh.ctrl;
                FLD_BASE_LO: reg_rdata = rd_sh.base[31:0];
                FLD_BASE_HI: reg_rdata = rd_sh.base[63:32];
                FLD_LIMIT:   reg_rdata = rd_sh.limit;
                FLD_TGT_LO:  reg_rdata = rd_sh.target[31:0];
                FLD_TGT_HI:  reg_rdata = rd_sh.target[63:32];
                default:     reg_rdata = 32'd0;
            endcase
        end
    end

    assign res_valid   = st_q.res.valid;
    assign res_hit     = st_q.res.hit;
    assign res_miss    = st_q.res.miss;
    assign res_cfg     = st_q.res.cfg;
    assign res_win     = st_q.res.win;
    assign res_addr    = st_q.res.addr;
    assign res_bus     = st_q.res.bus;
    assign res_devfn   = st_q.res.devfn;
    assign res_cfg_off = st_q.res.off;

endmodule

// File: rtl/xwu_checker.sv
module xwu_checker
    import xwu_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [11:0] reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        lk_valid,
    input logic        res_valid,
    input logic        res_hit,
    input logic        res_miss,
    input logic        res_cfg,
    input logic [3:0]  res_win
);

    assert_result_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_hit_miss_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_miss));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss));

    assert_cfg_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_cfg |-> res_hit);

    assert_win_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (32'(res_win) < NUM_WIN));

    assert_selector_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_VP) |=>
            ((reg_addr == OFF_VP) -> (reg_rdata == $past(reg_wdata))));

endmodule

bind xlat_window_unit xwu_checker #(.NUM_WIN(NUM_WIN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_cfg   (res_cfg),
    .res_win   (res_win)
);

// File: tb/xlat_window_unit_tb.sv
`timescale 1ns/1ps
module xlat_window_unit_tb_top;

    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic        lk_dir = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        res_valid, res_hit, res_miss, res_cfg;
    logic [3:0]  res_win;
    logic [63:0] res_addr;
    logic [7:0]  res_bus, res_devfn;
    logic [11:0] res_cfg_off;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xlat_window_unit #(.NUM_WIN(NW)) dut_i (.*);

    // reference model for the outbound bank (committed values)
    logic [63:0] m_base [NW];
    logic [31:0] m_lim  [NW];
    logic [63:0] m_tgt  [NW];
    logic        m_cfg  [NW];
    logic        m_en   [NW];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, {32'd0, reg_rdata}, {32'd0, exp});
    endtask

    task automatic look(input logic dir, input logic [63:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_dir = dir; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic look_hit(input string tag, input logic dir, input logic [63:0] a,
                            input logic [3:0] w, input logic [63:0] xa);
        look(dir, a);
        chk({tag, " hit"}, {63'd0, res_hit}, 64'd1);
        chk({tag, " win"}, {60'd0, res_win}, {60'd0, w});
        chk({tag, " addr"}, res_addr, xa);
    endtask

    task automatic look_miss(input string tag, input logic dir, input logic [63:0] a);
        look(dir, a);
        chk({tag, " miss"}, {62'd0, res_hit, res_miss}, 64'd1);
    endtask

    task automatic prog(input int w, input logic [63:0] b, input logic [31:0] l,
                        input logic [63:0] t, input logic c, input logic e);
        wr(12'h900, 32'(w));
        wr(12'h904, c ? 32'd4 : 32'd0);
        wr(12'h90C, b[31:0]);
        wr(12'h910, b[63:32]);
        wr(12'h914, l);
        wr(12'h918, t[31:0]);
        wr(12'h91C, t[63:32]);
        wr(12'h908, e ? 32'h8000_0000 : 32'd0);
        m_base[w] = b; m_lim[w] = l; m_tgt[w] = t; m_cfg[w] = c; m_en[w] = e;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd("R1 vp", 12'h900, 32'd0);
        rd("R1 limit", 12'h914, 32'hFFFF_FFFF);
        rd("R1 type", 12'h904, 32'd0);
        rd("R1 ctrl out", 12'h908, 32'd0);
        rd("R1 base", 12'h90C, 32'd0);
        // R11 default pass-through
        look_hit("R11 inbound", 1'b1, 64'h1234_5678, 4'd0, 64'h1234_5678);
        look_miss("R11 outbound", 1'b0, 64'h1234_5678);
        wr(12'h900, 32'h8000_0000);
        rd("R1 ctrl in0", 12'h908, 32'h8000_0000);

        // R2 selector readback
        wr(12'h900, 32'h8000_0003);
        rd("R2 vp", 12'h900, 32'h8000_0003);

        // R3 out-of-range index
        wr(12'h900, 32'h0000_0009);
        wr(12'h914, 32'h0000_1234);
        rd("R3 read zero", 12'h914, 32'd0);
        wr(12'h900, 32'h0000_0001);
        rd("R3 no alias", 12'h914, 32'hFFFF_FFFF);

        // R4 staging on outbound window 0
        wr(12'h900, 32'd0);
        wr(12'h90C, 32'h8000); wr(12'h914, 32'h8FFF); wr(12'h908, 32'h8000_0000);
        look_hit("R4 first", 1'b0, 64'h8800, 4'd0, 64'h800);
        wr(12'h90C, 32'h1000); wr(12'h914, 32'h1FFF);
        look_hit("R4 staged old", 1'b0, 64'h8800, 4'd0, 64'h800);
        look_miss("R4 staged new", 1'b0, 64'h1800);
        rd("R4 shadow", 12'h90C, 32'h1000);
        wr(12'h908, 32'h8000_0000);
        look_hit("R4 commit", 1'b0, 64'h1800, 4'd0, 64'h800);
        look_miss("R4 old gone", 1'b0, 64'h8800);

        // R6 edges
        look_hit("R6 low edge", 1'b0, 64'h1000, 4'd0, 64'h0);
        look_hit("R6 high edge", 1'b0, 64'h1FFF, 4'd0, 64'hFFF);
        look_miss("R6 below", 1'b0, 64'h0FFF);
        look_miss("R6 above", 1'b0, 64'h2000);

        // R7 memory translation
        wr(12'h918, 32'h4000_0000); wr(12'h91C, 32'h5);
        look_hit("R7 xlat", 1'b0, 64'h1800, 4'd0, 64'h5_4000_0800);

        // R9 target high write
        wr(12'h91C, 32'h7);
        rd("R9 tgt lo kept", 12'h918, 32'h4000_0000);
        rd("R9 tgt hi", 12'h91C, 32'h7);
        look_hit("R9 live", 1'b0, 64'h1800, 4'd0, 64'h7_4000_0800);

        // R5 disable
        wr(12'h908, 32'h0);
        look_miss("R5 disabled", 1'b0, 64'h1800);
        wr(12'h908, 32'h8000_0000);
        look_hit("R5 reenabled", 1'b0, 64'h1800, 4'd0, 64'h7_4000_0800);

        // R8 configuration window 1
        prog(1, 64'h2000_0000, 32'h2000_FFFF, 64'h0312_0000, 1'b1, 1'b1);
        look(1'b0, 64'h2000_0ABC);
        chk("R8 cfg flag", {62'd0, res_hit, res_cfg}, 64'd3);
        chk("R8 bus", {56'd0, res_bus}, 64'h03);
        chk("R8 devfn", {56'd0, res_devfn}, 64'h12);
        chk("R8 offset", {52'd0, res_cfg_off}, 64'hABC);

        // R10 priority
        prog(2, 64'h1800, 32'h27FF, 64'h0, 1'b0, 1'b1);
        look_hit("R10 lowest wins", 1'b0, 64'h1900, 4'd0, 64'h7_4000_0900);
        look_hit("R10 only w2", 1'b0, 64'h2100, 4'd2, 64'h900);

        // R12 direction select
        look(1'b1, 64'h2000_0ABC);
        chk("R12 inbound not cfg", {62'd0, res_hit, res_cfg}, 64'd2);
        chk("R12 inbound addr", res_addr, 64'h2000_0ABC);

        // random phase on the outbound bank
        for (int round = 0; round < 20; round++) begin
            for (int w = 0; w < NW; w++) begin
                logic [63:0] b;
                logic [63:0] t;
                b = {32'($urandom_range(0, 1)), 32'($urandom_range(0, 32'hFFFF)) << 4};
                t = {$urandom, $urandom};
                prog(w, b, b[31:0] + 32'($urandom_range(0, 32'h3FFFF)), t,
                     1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
            end
            for (int k = 0; k < 20; k++) begin
                logic [63:0] a;
                logic        eh;
                int          ew;
                a  = {32'($urandom_range(0, 1)), 32'($urandom_range(0, 32'h10_3FFF))};
                eh = 1'b0; ew = 0;
                for (int w = NW - 1; w >= 0; w--) begin
                    if (m_en[w] && a >= m_base[w] && a <= {m_base[w][63:32], m_lim[w]}) begin
                        eh = 1'b1; ew = w;
                    end
                end
                look(1'b0, a);
                chk("R10 rand hit", {63'd0, res_hit}, {63'd0, eh});
                if (eh) begin
                    chk("R10 rand win", {60'd0, res_win}, 64'(ew));
                    if (m_cfg[ew]) begin
                        chk("R8 rand cfg", {56'd0, res_bus, res_devfn},
                            {48'd0, m_tgt[ew][31:16]});
                        chk("R8 rand off", {52'd0, res_cfg_off},
                            {52'd0, 12'(a - m_base[ew])});
                    end else begin
                        chk("R7 rand addr", res_addr, m_tgt[ew] + (a - m_base[ew]));
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule